// File: doc/BRIEF.md
# DAC Channel Trigger and Data Controller

This block is the digital front end of one 12-bit digital-to-analog channel. Software writes samples over a 16-bit register port. There are three write formats, each at its own address, and all of them land in one 12-bit holding value. The block then copies that value into the output code register that drives the converter. The copy happens right after the write when triggering is off. When triggering is on, it happens on a chosen trigger instead.

The trigger can come from one external event line, from one of four timer trigger pulses, or from a software trigger bit. A rising edge on the selected source starts a transfer, which reaches the output a fixed number of cycles later. A hardware trigger can also raise a DMA request, which stays high until it is acknowledged. If a second hardware trigger arrives while that request is still pending, the block records a sticky underrun flag. That flag can drive an interrupt.

Top module: `dac_trig_ctrl`

## Requirements
- R1: A write to address 0x08 loads the holding value with wdata[11:0]. A read of 0x08 returns the holding value in bits [11:0].
- R2: A write to address 0x0C loads the holding value with wdata[15:4]. wdata[3:0] is ignored.
- R3: A write to address 0x10 loads the holding value with {wdata[7:0], 4'b0000}. wdata[15:8] is ignored.
- R4: With the channel enabled and trig_en clear, dac_code and a read of 0x2C take the holding value one clock cycle after the write to a holding address.
- R5: With trig_en set, the select field picks the trigger source: 0 is the external line, 1 to 4 are timer lines 0 to 3, and 7 is software. dac_code takes the holding value XFER_LAT+1 cycles after the first clock edge that samples a rising edge on the selected source. Writes to the holding addresses and edges on sources that are not selected leave dac_code unchanged.
- R6: With select 7, writing 1 to bit 0 of address 0x04 starts a transfer. The bit reads back 1 until the transfer completes and then clears itself. A software trigger never raises dma_req.
- R7: With dma_en set, each selected hardware trigger edge sets dma_req one cycle after the edge is sampled. dma_req stays high until a cycle with dma_ack high.
- R8: A hardware trigger that arrives while dma_req is high and dma_ack is low sets the underrun flag, which is bit 0 of address 0x34. Writing 1 to that bit clears it. irq is high exactly while the flag and udr_ie are both set.
- R9: The control register at 0x00 has these fields: bit 0 is the channel enable, bit 1 is buffer-off, bit 2 is trig_en, bits [5:3] are the trigger select, bit 12 is dma_en and bit 13 is udr_ie. While the channel is enabled, writes to the select field are ignored, but the other fields still take the written value.
- R10: While the channel enable is clear, dac_code stays 0 and all triggers, holding writes and DMA activity leave dac_code, dma_req and the underrun flag unchanged.
- R11: After reset, every register reads 0, and dac_code, dma_req and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ext_trig | input | 1 | External trigger event line |
| tim_trig | input | 4 | Timer trigger lines |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Underrun interrupt |
| dac_code | output | 12 | Code sent to the converter |

## Verification
The in-line assertions check the following on every cycle: dac_code is zero while the channel is disabled, the trigger select is held during enabled control writes, the output copy follows one cycle after an untriggered write, and the output stays stable between transfers in triggered mode. They also check that a DMA request is raised only by a hardware trigger, and that an underrun event sets the sticky flag. The bench scenarios are the only place to show the behaviour that needs context: the exact transfer latency for each trigger source, the mapping of each write format swept over many sample values, the self-clearing software bit, and the write-one-to-clear of the flag together with how irq depends on the enable bit.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int CODE_W = 12;
  localparam int BUS_W  = 16;
  localparam int N_TIM  = 4;
  localparam int N_LINE = N_TIM + 2;  // ext, timers, software

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_SWTG = 6'h04;
  localparam logic [5:0] A_R12  = 6'h08;
  localparam logic [5:0] A_L12  = 6'h0C;
  localparam logic [5:0] A_R8   = 6'h10;
  localparam logic [5:0] A_OUT  = 6'h2C;
  localparam logic [5:0] A_STAT = 6'h34;

  localparam logic [2:0] SEL_EXT = 3'd0;
  localparam logic [2:0] SEL_SW  = 3'd7;

  function automatic logic [CODE_W-1:0] fmt_r12(input logic [BUS_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] fmt_l12(input logic [BUS_W-1:0] w);
    return w[BUS_W-1:BUS_W-CODE_W];
  endfunction

  function automatic logic [CODE_W-1:0] fmt_r8(input logic [BUS_W-1:0] w);
    return {w[7:0], 4'b0000};
  endfunction

  // line index: 0 external, 1..N_TIM timers, N_TIM+1 software
  function automatic logic pick_edge(input logic [2:0] sel, input logic [N_LINE-1:0] e);
    logic r;
    r = 1'b0;
    if (sel == SEL_SW) r = e[N_LINE-1];
    else if (int'(sel) <= N_TIM) r = e[sel];
    return r;
  endfunction
endpackage

// File: rtl/dac_edge_bank.sv
module dac_edge_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] edges
);
  logic [N-1:0] samp_q;
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        samp_q[i] <= lines[i];
        prev_q[i] <= samp_q[i];
      end
    end
    assign edges[i] = samp_q[i] & ~prev_q[i];
  end
endmodule

// File: rtl/dac_xfer_pipe.sv
module dac_xfer_pipe #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic launch,
  output logic done
);
  logic [LAT-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else if (clr) stage_q[0] <= 1'b0;
    else stage_q[0] <= launch;
  end

  if (LAT > 1) begin : g_shift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[LAT-1:1] <= '0;
      else if (clr) stage_q[LAT-1:1] <= '0;
      else stage_q[LAT-1:1] <= stage_q[LAT-2:0];
    end
  end

  assign done = stage_q[LAT-1];
endmodule

// File: rtl/dac_dma_ctl.sv
module dac_dma_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hw_fire,
  input  logic dma_en,
  input  logic ack,
  output logic req,
  output logic udr_evt
);
  logic want;
  assign want    = hw_fire & dma_en;
  assign udr_evt = want & req & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else if (clr) req <= 1'b0;
    else if (want) req <= 1'b1;
    else if (ack) req <= 1'b0;
  end

  AST_DMA_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    want && !clr |=> req); // R7
  AST_DMA_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    !req && !hw_fire |=> !req); // R6
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_pkg::*;
#(
  parameter int XFER_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              ext_trig,
  input  logic [N_TIM-1:0]  tim_trig,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              irq,
  output logic [CODE_W-1:0] dac_code
);
  logic chan_en, buf_off, trig_en, dma_en, udr_ie;
  logic [2:0] trig_sel;
  logic [CODE_W-1:0] hold_q;
  logic hold_wr_q, sw_bit, udr_flag;

  logic wr_ctrl, wr_swtg, wr_r12, wr_l12, wr_r8, wr_stat, wr_hold;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_swtg = reg_wr && reg_addr == A_SWTG;
  assign wr_r12  = reg_wr && reg_addr == A_R12;
  assign wr_l12  = reg_wr && reg_addr == A_L12;
  assign wr_r8   = reg_wr && reg_addr == A_R8;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_hold = wr_r12 | wr_l12 | wr_r8;

  // control fields; select frozen while channel runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= 1'b0; buf_off <= 1'b0; trig_en <= 1'b0;
      trig_sel <= '0; dma_en <= 1'b0; udr_ie <= 1'b0;
    end else if (wr_ctrl) begin
      chan_en <= reg_wdata[0];
      buf_off <= reg_wdata[1];
      trig_en <= reg_wdata[2];
      if (!chan_en) trig_sel <= reg_wdata[5:3];
      dma_en  <= reg_wdata[12];
      udr_ie  <= reg_wdata[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_wr_q <= 1'b0;
    end else begin
      hold_wr_q <= wr_hold;
      if (wr_r12) hold_q <= fmt_r12(reg_wdata);
      else if (wr_l12) hold_q <= fmt_l12(reg_wdata);
      else if (wr_r8) hold_q <= fmt_r8(reg_wdata);
    end
  end

  // trigger path
  logic [N_LINE-1:0] lines, edges;
  logic sel_edge, fire, hw_fire, xfer_done, sw_mode, udr_evt;
  assign lines    = {sw_bit, tim_trig, ext_trig};
  assign sw_mode  = trig_sel == SEL_SW;
  assign sel_edge = pick_edge(trig_sel, edges);
  assign fire     = chan_en & trig_en & sel_edge;
  assign hw_fire  = fire & ~sw_mode;

  dac_edge_bank #(.N(N_LINE)) u_edges (
    .clk(clk), .rst_n(rst_n), .lines(lines), .edges(edges)
  );

  dac_xfer_pipe #(.LAT(XFER_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .clr(!chan_en), .launch(fire), .done(xfer_done)
  );

  dac_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .clr(!chan_en), .hw_fire(hw_fire),
    .dma_en(dma_en), .ack(dma_ack), .req(dma_req), .udr_evt(udr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_bit <= 1'b0;
    else if (!chan_en) sw_bit <= 1'b0;
    else if (xfer_done && sw_mode) sw_bit <= 1'b0;
    else if (wr_swtg && reg_wdata[0] && trig_en && sw_mode) sw_bit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_code <= '0;
    else if (!chan_en) dac_code <= '0;
    else if (trig_en ? xfer_done : hold_wr_q) dac_code <= hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) udr_flag <= 1'b0;
    else if (udr_evt) udr_flag <= 1'b1;
    else if (wr_stat && reg_wdata[0]) udr_flag <= 1'b0;
  end

  assign irq = udr_flag & udr_ie;

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, udr_ie, dma_en, 6'b0, trig_sel, trig_en, buf_off, chan_en};
      A_SWTG:  reg_rdata = {15'b0, sw_bit};
      A_R12:   reg_rdata = {4'b0, hold_q};
      A_L12:   reg_rdata = {hold_q, 4'b0};
      A_R8:    reg_rdata = {8'b0, hold_q[11:4]};
      A_OUT:   reg_rdata = {4'b0, dac_code};
      A_STAT:  reg_rdata = {15'b0, udr_flag};
      default: reg_rdata = '0;
    endcase
  end

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> dac_code == '0); // R10
  AST_SEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && chan_en |=> trig_sel == $past(trig_sel)); // R9
  AST_IMM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr_q && chan_en && !trig_en && !wr_ctrl |=> dac_code == $past(hold_q)); // R4
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en && trig_en && !xfer_done && !wr_ctrl |=> $stable(dac_code)); // R5
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udr_evt |=> udr_flag); // R8
endmodule

// File: tb/dac_trig_ctrl_bench.sv
module dac_trig_ctrl_bench;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ext = 1'b0;
  logic [3:0] tim = '0;
  logic ack = 1'b0;
  logic req, irq;
  logic [11:0] code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_trig_ctrl #(.XFER_LAT(LAT)) u_dac_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ext_trig(ext), .tim_trig(tim), .dma_ack(ack),
    .dma_req(req), .irq(irq), .dac_code(code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic set_line(input int src, input logic v);
    if (src == 0) ext = v;
    else tim[src-1] = v;
  endtask

  task automatic pulse(input int src);
    set_line(src, 1'b1);
    @(negedge clk);
    set_line(src, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int rv, expv, prev, word, ctl;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    foreach (rv_addrs[k]) begin
      bus_rd(rv_addrs[k], rv);
      chk("R11 reg zero", rv, 0);
    end
    chk("R11 code", int'(code), 0);
    chk("R11 req", int'(req), 0);
    chk("R11 irq", int'(irq), 0);

    // untriggered, three formats swept
    bus_wr(6'h00, 16'h0001);
    prev = 0;
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 16; i++) begin
        int v;
        v = (i * 273 + f * 17) % 4096;
        if (f == 0) begin word = v | ((i & 15) << 12); expv = v; end
        else if (f == 1) begin word = (v << 4) | (i & 15); expv = v; end
        else begin word = v | 16'hA500; expv = (v & 255) << 4; end
        bus_wr(f == 0 ? 6'h08 : (f == 1 ? 6'h0C : 6'h10), word[15:0]);
        chk("R4 before copy", int'(code), prev);
        @(negedge clk);
        if (f == 0) chk("R1 r12 code", int'(code), expv);
        else if (f == 1) chk("R2 l12 code", int'(code), expv);
        else chk("R3 r8 code", int'(code), expv);
        bus_rd(6'h2C, rv);
        chk("R4 out reg", rv, expv);
        bus_rd(6'h08, rv);
        chk("R1 hold readback", rv, expv);
        prev = expv;
      end
    end

    // triggered mode, each source
    for (int s = 0; s < 6; s++) begin
      int sel, val, other;
      sel = (s == 5) ? 7 : s;
      val = 100 + s * 531;
      ctl = (sel << 3) | 4 | (1 << 12);
      bus_wr(6'h00, 16'h0000);
      bus_wr(6'h00, ctl[15:0]);
      bus_wr(6'h00, ctl[15:0] | 16'h0001);
      bus_rd(6'h00, rv);
      chk("R9 ctrl readback", rv, ctl | 1);
      bus_wr(6'h08, val[15:0]);
      @(negedge clk);
      chk("R5 no copy on write", int'(code), 0);
      other = (sel == 0) ? 1 : 0;
      pulse(other);
      repeat (LAT) @(negedge clk);
      chk("R5 unselected ignored", int'(code), 0);
      chk("R5 unselected no req", int'(req), 0);
      if (sel != 7) begin
        set_line(sel, 1'b1);
        repeat (LAT + 1) @(negedge clk);
        chk("R5 latency early", int'(code), 0);
        @(negedge clk);
        chk("R5 latency on time", int'(code), val);
        set_line(sel, 1'b0);
        chk("R7 req raised", int'(req), 1);
        @(negedge clk);
        chk("R7 req held", int'(req), 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R7 req cleared by ack", int'(req), 0);
      end else begin
        bus_wr(6'h04, 16'h0001);
        bus_rd(6'h04, rv);
        chk("R6 sw bit set", rv, 1);
        repeat (LAT + 1) @(negedge clk);
        chk("R6 sw early", int'(code), 0);
        @(negedge clk);
        chk("R6 sw transfer", int'(code), val);
        bus_rd(6'h04, rv);
        chk("R6 sw self clear", rv, 0);
        chk("R6 sw no dma", int'(req), 0);
      end
    end

    // underrun with interrupt enabled, external source
    ctl = 4 | (1 << 12) | (1 << 13);
    bus_wr(6'h00, 16'h0000);
    bus_wr(6'h00, ctl[15:0] | 16'h0001);
    pulse(0);
    chk("R8 no flag first", int'(irq), 0);
    pulse(0);
    bus_rd(6'h34, rv);
    chk("R8 flag set", rv, 1);
    chk("R8 irq", int'(irq), 1);
    bus_wr(6'h34, 16'h0001);
    bus_rd(6'h34, rv);
    chk("R8 w1c", rv, 0);
    chk("R8 irq cleared", int'(irq), 0);

    // R9 select locked, other fields accepted; irq masked
    bus_wr(6'h00, 16'h1015);
    bus_rd(6'h00, rv);
    chk("R9 sel locked", rv, 16'h1005);
    pulse(0);
    bus_rd(6'h34, rv);
    chk("R8 flag w/o ie", rv, 1);
    chk("R8 irq masked", int'(irq), 0);
    bus_wr(6'h00, 16'h3005);
    chk("R8 irq unmasked", int'(irq), 1);
    bus_wr(6'h34, 16'h0001);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R7 ack drop", int'(req), 0);

    // R10 disabled channel
    bus_wr(6'h00, 16'h3004);
    bus_wr(6'h08, 16'h0ABC);
    pulse(0);
    pulse(0);
    repeat (LAT) @(negedge clk);
    chk("R10 code zero", int'(code), 0);
    chk("R10 no req", int'(req), 0);
    bus_rd(6'h34, rv);
    chk("R10 no flag", rv, 0);
    bus_wr(6'h00, 16'h0000);
    bus_wr(6'h00, 16'h0001);
    bus_wr(6'h10, 16'h00FF);
    @(negedge clk);
    chk("R3 r8 full byte", int'(code), 16'h0FF0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [5:0] rv_addrs [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h2C, 6'h34};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule